// File: doc/BRIEF.md
# Trimmed-Packet Loss Detector with Retransmit-Request Queue

This receiver-side block examines one parsed packet header per cycle and decides whether the packet is a trimmed congestion signal. A switch that trims a packet keeps only its headers and rewrites the DSCP to a dedicated codepoint. The block treats that packet as an immediate loss report and does not wait for a timeout.

A packet is trimmed when its DSCP equals the configured codepoint and its received length is shorter than the length its header declares. For such a packet the block copies the sequence number and the delivery-context identifier out of the preserved transport header. It queues a selective negative-acknowledgment request with the retransmit flag set, in a small FIFO that a transmit path drains through valid/ready. Packets with any other DSCP are handed to the data consumer as a one-cycle delivery strobe. A packet that carries the trimmed codepoint but also its full payload is a protocol violation: it is counted and discarded. When the queue is full, a new request is dropped and counted.

Top module: `trim_nack_gen`

## Requirements
- R1: A header with `hdr_valid`=1, `hdr_dscp` equal to `TRIM_DSCP` (default 6'h0A) and `hdr_rx_len` < `hdr_decl_len` enqueues exactly one NACK request and does not assert `deliver_o`.
- R2: Each NACK record presents the PSN and context ID of its trimmed header on `nack_psn` and `nack_ctx`, with `nack_retx`=1.
- R3: With the queue empty, `nack_valid` rises in the first cycle after the clock edge that samples the trimmed header. No timer is involved.
- R4: A valid header whose DSCP differs from `TRIM_DSCP` pulses `deliver_o` for one cycle, one cycle later, whatever its lengths are, and creates no NACK.
- R5: A valid header with DSCP equal to `TRIM_DSCP` and `hdr_rx_len` >= `hdr_decl_len` increments `err_cnt` by one. It creates no NACK and no delivery.
- R6: Records leave in arrival order. While `nack_valid`=1 and `nack_ready`=0, the record and `nack_valid` hold steady.
- R7: If the queue holds `DEPTH` records before the edge, the new request is dropped and `ovf_cnt` increments, even if a record leaves at that same edge.
- R8: `err_cnt` and `ovf_cnt` saturate at all ones.
- R9: After reset, `nack_valid`, `deliver_o`, `err_cnt` and `ovf_cnt` are all zero.
- R10: A header with `hdr_valid`=0 has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdr_valid | input | 1 | Header present this cycle |
| hdr_dscp | input | 6 | DSCP of the packet |
| hdr_rx_len | input | LEN_W | Length actually received |
| hdr_decl_len | input | LEN_W | Length declared in the header |
| hdr_psn | input | PSN_W | Packet sequence number |
| hdr_ctx | input | CTX_W | Delivery-context identifier |
| nack_valid | output | 1 | A NACK request is presented |
| nack_ready | input | 1 | Transmit path accepts the request |
| nack_psn | output | PSN_W | PSN to retransmit |
| nack_ctx | output | CTX_W | Context of the lost packet |
| nack_retx | output | 1 | Retransmit flag |
| deliver_o | output | 1 | Non-trimmed packet handed to the data consumer |
| err_cnt | output | CNT_W | Trimmed-codepoint packets that had a full payload |
| ovf_cnt | output | CNT_W | Requests dropped on a full queue |

## Verification
Every result follows the sampling edge by exactly one cycle. `deliver_o`, the counters and a NACK into an empty queue all appear right after the edge that takes the header. The bench drives a header just after a rising edge and checks these outputs just after the next rising edge.

The scoreboard predicts queue occupancy at the falling edge before each header edge. It adds a record only when the design had room, and it counts a drop otherwise. The monitor compares a record at the falling edge before the transfer edge, which is where `nack_valid` and `nack_ready` are both settled.

// File: rtl/trim_nack_pkg.sv
package trim_nack_pkg;
  typedef enum logic [1:0] {
    PKT_NONE      = 2'd0,
    PKT_DATA      = 2'd1,
    PKT_TRIM      = 2'd2,
    PKT_MALFORMED = 2'd3
  } pkt_kind_e;
endpackage

// File: rtl/trim_classify.sv
module trim_classify
  import trim_nack_pkg::*;
#(
  parameter logic [5:0] TRIM_DSCP = 6'h0A,
  parameter int LEN_W = 14
) (
  input  logic             valid_i,
  input  logic [5:0]       dscp_i,
  input  logic [LEN_W-1:0] rx_len_i,
  input  logic [LEN_W-1:0] decl_len_i,
  output pkt_kind_e        kind_o
);
  logic marked;
  logic short_len;

  always_comb begin
    marked    = (dscp_i == TRIM_DSCP);
    short_len = (rx_len_i < decl_len_i);
    if (!valid_i)       kind_o = PKT_NONE;
    else if (!marked)   kind_o = PKT_DATA;
    else if (short_len) kind_o = PKT_TRIM;
    else                kind_o = PKT_MALFORMED;
  end
endmodule

// File: rtl/trim_sat_cnt.sv
module trim_sat_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};
  logic         en;
  logic [W-1:0] cnt_d;

  always_comb begin
    en    = inc_i && (cnt_o != MAXV);
    cnt_d = cnt_o + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_o <= '0;
    else if (en) cnt_o <= cnt_d;
  end
endmodule

// File: rtl/trim_nack_fifo.sv
module trim_nack_fifo #(
  parameter int W     = 49,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  output logic         drop_o,
  output logic         valid_o,
  input  logic         ready_i,
  output logic [W-1:0] data_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0] FULLV = AW'(DEPTH) | (AW+1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, wr_ptr_d, rd_ptr_d;
  logic [AW:0]   count, count_d;
  logic          full, do_push, do_pop;

  always_comb begin
    full     = (count == FULLV);
    do_push  = push_i && !full;
    drop_o   = push_i && full;
    valid_o  = (count != '0);
    do_pop   = valid_o && ready_i;
    data_o   = mem[rd_ptr];
    wr_ptr_d = (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
    rd_ptr_d = (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
    count_d  = count + {{AW{1'b0}}, do_push} - {{AW{1'b0}}, do_pop};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr_d;
      if (do_pop)  rd_ptr <= rd_ptr_d;
      count <= count_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= data_i;
  end
endmodule

// File: rtl/trim_nack_gen.sv
module trim_nack_gen
  import trim_nack_pkg::*;
#(
  parameter logic [5:0] TRIM_DSCP = 6'h0A,
  parameter int LEN_W = 14,
  parameter int PSN_W = 32,
  parameter int CTX_W = 16,
  parameter int DEPTH = 4,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hdr_valid,
  input  logic [5:0]       hdr_dscp,
  input  logic [LEN_W-1:0] hdr_rx_len,
  input  logic [LEN_W-1:0] hdr_decl_len,
  input  logic [PSN_W-1:0] hdr_psn,
  input  logic [CTX_W-1:0] hdr_ctx,
  output logic             nack_valid,
  input  logic             nack_ready,
  output logic [PSN_W-1:0] nack_psn,
  output logic [CTX_W-1:0] nack_ctx,
  output logic             nack_retx,
  output logic             deliver_o,
  output logic [CNT_W-1:0] err_cnt,
  output logic [CNT_W-1:0] ovf_cnt
);
  localparam int REC_W = 1 + PSN_W + CTX_W;

  pkt_kind_e        kind;
  logic             push, drop, deliver_d;
  logic [REC_W-1:0] rec_in, rec_out;

  trim_classify #(.TRIM_DSCP(TRIM_DSCP), .LEN_W(LEN_W)) u_cls (
    .valid_i(hdr_valid), .dscp_i(hdr_dscp), .rx_len_i(hdr_rx_len),
    .decl_len_i(hdr_decl_len), .kind_o(kind)
  );

  always_comb begin
    push      = (kind == PKT_TRIM);
    deliver_d = (kind == PKT_DATA);
    rec_in    = {1'b1, hdr_psn, hdr_ctx};
    {nack_retx, nack_psn, nack_ctx} = rec_out;
  end

  trim_nack_fifo #(.W(REC_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push_i(push), .data_i(rec_in), .drop_o(drop),
    .valid_o(nack_valid), .ready_i(nack_ready), .data_o(rec_out)
  );

  trim_sat_cnt #(.W(CNT_W)) u_err (
    .clk(clk), .rst_n(rst_n), .inc_i(kind == PKT_MALFORMED), .cnt_o(err_cnt)
  );

  trim_sat_cnt #(.W(CNT_W)) u_ovf (
    .clk(clk), .rst_n(rst_n), .inc_i(drop), .cnt_o(ovf_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) deliver_o <= 1'b0;
    else        deliver_o <= deliver_d;
  end
endmodule

// File: rtl/trim_nack_gen_chk.sv
module trim_nack_gen_chk #(
  parameter logic [5:0] TRIM_DSCP = 6'h0A,
  parameter int LEN_W = 14,
  parameter int PSN_W = 32,
  parameter int CTX_W = 16,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hdr_valid,
  input logic [5:0]       hdr_dscp,
  input logic [LEN_W-1:0] hdr_rx_len,
  input logic [LEN_W-1:0] hdr_decl_len,
  input logic             nack_valid,
  input logic             nack_ready,
  input logic [PSN_W-1:0] nack_psn,
  input logic [CTX_W-1:0] nack_ctx,
  input logic             nack_retx,
  input logic             deliver_o,
  input logic [CNT_W-1:0] err_cnt,
  input logic [CNT_W-1:0] ovf_cnt
);
  // R3
  nack_prompt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && hdr_dscp == TRIM_DSCP && hdr_rx_len < hdr_decl_len && !nack_valid
    |=> nack_valid);

  // R6
  nack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nack_valid && !nack_ready |=> nack_valid && $stable(nack_psn) && $stable(nack_ctx));

  // R2
  nack_retx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nack_valid |-> nack_retx);

  // R4
  deliver_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deliver_o |-> $past(hdr_valid) && $past(hdr_dscp) != TRIM_DSCP);

  // R5
  err_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && hdr_dscp == TRIM_DSCP && hdr_rx_len >= hdr_decl_len && err_cnt != {CNT_W{1'b1}}
    |=> err_cnt == $past(err_cnt) + 1'b1);

  // R7
  ovf_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_cnt != $past(ovf_cnt) |-> $past(nack_valid));
endmodule

bind trim_nack_gen trim_nack_gen_chk #(
  .TRIM_DSCP(TRIM_DSCP), .LEN_W(LEN_W), .PSN_W(PSN_W), .CTX_W(CTX_W), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/trim_nack_gen_test.sv
module trim_nack_gen_test;
  localparam logic [5:0] TRIM = 6'h0A;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hdr_valid = 1'b0;
  logic [5:0]  hdr_dscp = '0;
  logic [13:0] hdr_rx_len = '0, hdr_decl_len = '0;
  logic [31:0] hdr_psn = '0;
  logic [15:0] hdr_ctx = '0;
  logic        nack_valid, nack_ready, nack_retx, deliver_o;
  logic [31:0] nack_psn;
  logic [15:0] nack_ctx;
  logic [7:0]  err_cnt, ovf_cnt;

  int errors = 0, checks = 0;
  int rdy_mode = 1;
  logic [7:0] lfsr = 8'h5B;
  logic [47:0] sbq[$];
  int exp_err = 0, exp_ovf = 0;

  always #4 clk = ~clk;

  trim_nack_gen uut (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    nack_ready = (rdy_mode == 1) ? 1'b1 : (rdy_mode == 0) ? 1'b0 : lfsr[0];
  end

  // monitor: transfer happens at the next rising edge
  always @(negedge clk) begin
    if (rst_n && nack_valid && nack_ready) begin
      if (sbq.size() == 0) chk(0, "R1 unexpected NACK", nack_psn, -1);
      else begin
        logic [47:0] e;
        e = sbq.pop_front();
        chk(nack_psn == e[47:16], "R2/R6 psn", nack_psn, e[47:16]);
        chk(nack_ctx == e[15:0], "R2 ctx", nack_ctx, e[15:0]);
        chk(nack_retx == 1'b1, "R2 retx", nack_retx, 1);
      end
    end
  end

  // called just after a rising edge; returns just after the next one
  task automatic send(input logic [5:0] d, input int rx, input int decl,
                      input int psn, input int ctx, input bit v = 1'b1);
    bit trim, mal, data, was_empty;
    int occ;
    hdr_valid = v; hdr_dscp = d; hdr_rx_len = 14'(rx); hdr_decl_len = 14'(decl);
    hdr_psn = psn; hdr_ctx = 16'(ctx);
    trim = v && d == TRIM && rx < decl;
    mal  = v && d == TRIM && rx >= decl;
    data = v && d != TRIM;
    @(negedge clk); #1;
    occ = sbq.size() + ((nack_valid && nack_ready) ? 1 : 0);
    was_empty = (occ == 0);
    if (trim) begin
      if (occ < DEPTH) sbq.push_back({32'(psn), 16'(ctx)});
      else if (exp_ovf < 255) exp_ovf++;
    end
    if (mal && exp_err < 255) exp_err++;
    @(posedge clk); #1;
    hdr_valid = 1'b0;
    chk(deliver_o == data, "R4/R1/R5/R10 deliver", deliver_o, data);
    chk(err_cnt == 8'(exp_err), "R5/R8 err_cnt", err_cnt, exp_err);
    chk(ovf_cnt == 8'(exp_ovf), "R7/R8 ovf_cnt", ovf_cnt, exp_ovf);
    if (trim && was_empty) chk(nack_valid == 1'b1, "R3 prompt NACK", nack_valid, 1);
  endtask

  task automatic drain();
    rdy_mode = 1;
    while (sbq.size() != 0) @(posedge clk);
    @(posedge clk); #1;
    chk(nack_valid == 1'b0, "R1 queue empty after drain", nack_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R9 reset state
    chk(nack_valid == 0, "R9 nack_valid", nack_valid, 0);
    chk(deliver_o == 0, "R9 deliver", deliver_o, 0);
    chk(err_cnt == 0 && ovf_cnt == 0, "R9 counters", err_cnt, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R4 data packets of varied lengths, R1/R3 single trims
    send(6'h00, 1500, 1500, 1, 1);
    send(6'h0B, 64, 1500, 2, 2);
    send(TRIM, 64, 4096, 100, 7);
    send(6'h1A, 2000, 100, 3, 3);
    send(TRIM, 128, 129, 101, 8);
    // R10 invalid trimmed header
    send(TRIM, 64, 4096, 999, 9, 1'b0);
    // R5 malformed
    send(TRIM, 4096, 4096, 200, 1);
    send(TRIM, 5000, 4096, 201, 1);
    drain();

    // R7 overflow with stalled consumer, R6 ordering and hold
    rdy_mode = 0;
    @(posedge clk); #1;
    for (int i = 0; i < DEPTH + 2; i++) send(TRIM, 64, 1024, 300 + i, 40 + i);
    repeat (3) @(posedge clk); #1;
    chk(nack_valid == 1 && nack_psn == 300, "R6 held head", nack_psn, 300);
    chk(ovf_cnt == 2, "R7 drops", ovf_cnt, 2);
    drain();

    // mixed traffic with random ready
    rdy_mode = 2;
    for (int i = 0; i < 80; i++) begin
      case (i % 5)
        0, 2: send(TRIM, 64 + i, 3000, 500 + i, i);
        1: send(6'h12, 900, 900, 500 + i, i);
        3: send(TRIM, 3000, 3000, 500 + i, i);
        default: send(TRIM, 64, 65, 500 + i, i);
      endcase
    end
    drain();

    // R8 saturation of err_cnt
    for (int i = 0; i < 260; i++) send(TRIM, 200, 100, i, 0);
    chk(err_cnt == 8'hFF, "R8 err saturate", err_cnt, 255);
    drain();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule